// File: doc/BRIEF.md
# SRAM Data-Retention Power Sequencer

This block sits between a memory access controller and a battery-backed static RAM. It decides when the RAM's chip select has to be held deasserted because the supply is about to fall or has only just returned. A supervisor supplies two asynchronous digital flags: an early power-fail warning and a power-good indication. The access controller supplies a busy flag that marks an access in flight. The block returns three signals: a chip-select-high override, a retention status, and a permission flag that the access controller must see before it starts a new access.

When the warning arrives, the sequencer lets any access in flight finish, so it never cuts a write pulse short. It then forces chip select high before the supply can leave its operating range. While chip select is high, the RAM ignores its address, control and data inputs and keeps its contents down to about 2 V. When the supply is good again, the sequencer holds chip select high for at least one full read-cycle time, rounded up to whole clocks, before it grants access. Reset puts the block in that same recovery wait, so the first access after power-up is also delayed.

Top module: `sram_retention_seq`

## Requirements
- R1: While reset is asserted and directly after its release, acc_allow_o is 0, cs_force_hi_o is 1 and retain_o is 0. The first grant after reset comes only after the recovery wait of R5, counted from when power-good is seen high. Assertion of rst_n takes effect without a clock.
- R2: A power-fail warning with no access in flight moves the block to retention: retain_o=1, cs_force_hi_o=1, acc_allow_o=0.
- R3: A power-fail warning that arrives while acc_busy_i=1 drops acc_allow_o but keeps cs_force_hi_o=0. cs_force_hi_o and retain_o go high on the first clock edge at which acc_busy_i is seen low.
- R4: In retention the block stays in retention, whatever acc_busy_i does, for as long as power-fail is 1 or power-good is 0.
- R5: Retention ends when power-good=1 and power-fail=0. The block then spends exactly N = ceil(TRC_PS / CLK_PERIOD_PS) cycles in recovery (7 with the defaults 55 ns and 8 ns) with retain_o=0, cs_force_hi_o=1 and acc_allow_o=0. After that, acc_allow_o=1 and cs_force_hi_o=0.
- R6: A power-fail warning during recovery sends the block back to retention without acc_allow_o ever rising.
- R7: If power-good is seen low during recovery, the recovery count restarts from zero. The full N cycles are then counted again once power-good is seen high.
- R8: Power-fail and power-good each pass through SYNC_STAGES flops, 2 by default. With the default, a change driven just after clock edge k is acted on at edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_fail_i | input | 1 | Early warning that the supply is about to fall (asynchronous) |
| pwr_good_i | input | 1 | Supply is inside its operating range (asynchronous) |
| acc_busy_i | input | 1 | Access controller has an access in flight (synchronous) |
| cs_force_hi_o | output | 1 | Override that holds the RAM chip select deasserted |
| retain_o | output | 1 | Block is in data-retention state |
| acc_allow_o | output | 1 | New RAM accesses may start |

## Verification
Responses to the supply flags appear three clock edges after the flag is driven: two synchronizer flops, then the state register. The grant comes N further edges after the block enters recovery. A busy flag going low is answered on the very next edge. The bench drives inputs and samples outputs 2 ns after each edge. It counts edges from a known entry point and compares every output, in every cycle of each window, with values worked out from these latencies. It sweeps the instant of the power-fail warning across the whole recovery window and past its end, and sweeps the length of the busy tail from zero to four cycles. After reset, with power-good already high, the first grant falls N+4 edges after reset release.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_DRAIN   = 2'd1,
    ST_RETAIN  = 2'd2,
    ST_RECOVER = 2'd3
  } rs_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/rs_rst_sync.sv
module rs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] st_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= '0;
      else        st_q <= {st_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = st_q[STAGES-1];
  end
endmodule

// File: rtl/rs_recov_cnt.sv
module rs_recov_cnt #(
  parameter int unsigned CYCLES = 7,
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = '0;
    else if (en_i && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import rs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pf_s_i,
  input  logic      pg_s_i,
  input  logic      busy_i,
  input  logic      cnt_done_i,
  output rs_state_e state_o,
  output logic      cnt_en_o,
  output logic      cnt_clr_o
);
  rs_state_e state_q, state_d;
  logic      supply_drop;

  assign supply_drop = pf_s_i | ~pg_s_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (supply_drop) state_d = busy_i ? ST_DRAIN : ST_RETAIN;
      end
      ST_DRAIN: begin
        if (!busy_i) state_d = ST_RETAIN;
      end
      ST_RETAIN: begin
        if (pg_s_i && !pf_s_i) state_d = ST_RECOVER;
      end
      ST_RECOVER: begin
        if (pf_s_i)                    state_d = ST_RETAIN;
        else if (pg_s_i && cnt_done_i) state_d = ST_NORMAL;
      end
      default: state_d = ST_RECOVER;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RECOVER;
    else        state_q <= state_d;
  end

  assign cnt_en_o  = (state_q == ST_RECOVER) && pg_s_i && !pf_s_i;
  assign cnt_clr_o = (state_q != ST_RECOVER) || !pg_s_i;
  assign state_o   = state_q;
endmodule

// File: rtl/sram_retention_seq.sv
module sram_retention_seq
  import rs_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned TRC_PS        = 55000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_fail_i,
  input  logic pwr_good_i,
  input  logic acc_busy_i,
  output logic cs_force_hi_o,
  output logic retain_o,
  output logic acc_allow_o
);
  localparam int unsigned RECOV_CYCLES = ceil_div(TRC_PS, CLK_PERIOD_PS);

  logic      rst_q_n;
  logic      pf_s, pg_s;
  logic      cnt_en, cnt_clr, cnt_done;
  rs_state_e state;

  rs_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  rs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_flag_sync (
    .clk   (clk),
    .rst_n (rst_q_n),
    .d_i   ({pwr_good_i, pwr_fail_i}),
    .q_o   ({pg_s, pf_s})
  );

  rs_recov_cnt #(.CYCLES(RECOV_CYCLES)) i_recov_cnt (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .clr_i  (cnt_clr),
    .en_i   (cnt_en),
    .done_o (cnt_done)
  );

  rs_fsm i_fsm (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .pf_s_i     (pf_s),
    .pg_s_i     (pg_s),
    .busy_i     (acc_busy_i),
    .cnt_done_i (cnt_done),
    .state_o    (state),
    .cnt_en_o   (cnt_en),
    .cnt_clr_o  (cnt_clr)
  );

  always_comb begin
    cs_force_hi_o = (state == ST_RETAIN) || (state == ST_RECOVER);
    retain_o      = (state == ST_RETAIN);
    acc_allow_o   = (state == ST_NORMAL);
  end
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int unsigned RECOV_CYCLES = 7,
  localparam int unsigned RW = $clog2(RECOV_CYCLES + 1)
) (
  input logic clk,
  input logic rst_q_n,
  input logic pf_s,
  input logic pg_s,
  input logic busy,
  input logic force_hi,
  input logic retain,
  input logic allow
);
  localparam logic [RW-1:0] SAT = RW'(RECOV_CYCLES);

  logic          in_recov;
  logic [RW-1:0] run_q;

  assign in_recov = force_hi && !retain;

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)        run_q <= '0;
    else if (!in_recov)  run_q <= '0;
    else if (run_q != SAT) run_q <= run_q + 1'b1;
  end

  assert_recovery_wait_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(allow) |-> (run_q >= SAT));

  assert_no_cut_access_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(force_hi) |-> !$past(busy));

  assert_abort_recovery_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (in_recov && pf_s) |=> (retain && !allow));

  assert_hold_retention_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (retain && (pf_s || !pg_s)) |=> retain);

  assert_retain_cause_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(retain) |-> ($past(pf_s) || !$past(pg_s) || $past(busy) == 1'b0));

  assert_grant_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_q_n)
    allow |-> !force_hi);
endmodule

bind sram_retention_seq rs_checker #(.RECOV_CYCLES(RECOV_CYCLES)) i_rs_checker (
  .clk      (clk),
  .rst_q_n  (rst_q_n),
  .pf_s     (pf_s),
  .pg_s     (pg_s),
  .busy     (acc_busy_i),
  .force_hi (cs_force_hi_o),
  .retain   (retain_o),
  .allow    (acc_allow_o)
);

// File: tb/test_sram_retention_seq.sv
`timescale 1ns/1ps
module test_sram_retention_seq;
  localparam int N = 7;   // ceil(55000/8000)
  localparam int L = 3;   // sync stages + state register

  logic clk = 1'b0;
  logic rst_n, pf, pg, busy;
  logic force_hi, retain, allow;
  int   checks = 0;
  int   errors = 0;

  always #4 clk = ~clk;

  sram_retention_seq i_sram_retention_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_fail_i    (pf),
    .pwr_good_i    (pg),
    .acc_busy_i    (busy),
    .cs_force_hi_o (force_hi),
    .retain_o      (retain),
    .acc_allow_o   (allow)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk3(input string req, input logic ef, input logic er, input logic ea);
    chk(req, "cs_force_hi_o", force_hi, ef);
    chk(req, "retain_o", retain, er);
    chk(req, "acc_allow_o", allow, ea);
  endtask

  initial begin
    #160000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pf = 1'b0; pg = 1'b1; busy = 1'b0;
    tick(3);
    chk3("R1", 1'b1, 1'b0, 1'b0);
    rst_n = 1'b1;
    chk3("R1", 1'b1, 1'b0, 1'b0);
    tick(N + 3);
    chk3("R1", 1'b1, 1'b0, 1'b0);
    tick(1);
    chk3("R1", 1'b0, 1'b0, 1'b1);

    // R2 and R8: idle power-fail, seen three edges later
    pf = 1'b1;
    tick(L - 1);
    chk3("R8", 1'b0, 1'b0, 1'b1);
    tick(1);
    chk3("R2", 1'b1, 1'b1, 1'b0);

    // R4: retention holds whatever busy does while pf=1 or pg=0
    pg = 1'b0;
    for (int i = 0; i < 12; i++) begin
      busy = i[0];
      pf   = i[1];
      tick(1);
      chk3("R4", 1'b1, 1'b1, 1'b0);
    end
    busy = 1'b0; pf = 1'b1;
    tick(L);

    // R5/R6 sweep: warning at each offset d cycles into recovery
    for (int d = 0; d < N + 3; d++) begin
      pf = 1'b0; pg = 1'b1;
      tick(L);
      for (int c = 0; c <= d + L; c++) begin
        chk3((d + L < N) ? "R6" : "R5",
             !(c >= N && c < d + L), (c >= d + L), (c >= N && c < d + L));
        if (c == d) pf = 1'b1;
        tick(1);
      end
    end

    // R7: power-good glitch during recovery restarts the count
    pf = 1'b0; pg = 1'b1;
    tick(L);
    for (int c = 0; c <= N + 5; c++) begin
      chk3("R7", (c < N + 5), 1'b0, (c >= N + 5));
      if (c == 2) pg = 1'b0;
      if (c == 3) pg = 1'b1;
      tick(1);
    end

    // R3 sweep: busy tail of b cycles after the warning is acted on
    for (int b = 0; b < 5; b++) begin
      busy = 1'b1; pf = 1'b1;
      tick(L - 1);
      chk3("R8", 1'b0, 1'b0, 1'b1);
      tick(1);
      for (int c = 0; c <= b + 1; c++) begin
        chk3("R3", (c >= b + 1), (c >= b + 1), 1'b0);
        if (c == b) busy = 1'b0;
        tick(1);
      end
      pf = 1'b0; pg = 1'b1;
      tick(L + N);
      chk3("R5", 1'b0, 1'b0, 1'b1);
    end

    // R1: asynchronous reset assertion from normal state
    rst_n = 1'b0;
    #1;
    chk3("R1", 1'b1, 1'b0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule